// File: doc/BRIEF.md
# Split Memory Block Address Remapper

This unit sits in a memory controller between the CPU address path and the RAM and ROM arrays. It holds two byte-wide control registers, written and read through a small register port. From them it decides three things. The first is where conventional low RAM ends. The second is whether the 128 KB window at 0xE0000–0xFFFFF answers reads from ROM or from shadow RAM. The third is whether the leftover block of physical RAM that the low-memory hole displaces shows up again at a programmable megabyte boundary.

For every CPU access the unit produces a translated physical address and exactly one target select: low RAM, split block, ROM, shadow RAM, or write inhibit. An access that matches none of these raises no select. Translation into the split block uses the CPU address modulo the block size, plus a physical origin. The block size and the origin both depend on a control bit. The decode is combinational from the current CPU address, the strobes and the registered control state.

Top module: `split_remap_unit`

## Requirements
- R1: After reset the base register reads 0x00 and the control register reads 0x02, so the top window reads from ROM.
- R2: Register address 0 reads the base register and address 1 reads the control register. Any other register address reads 0xFF, and a write to it changes neither register.
- R3: A register write takes effect on the clock edge that samples it. Before that edge, the readback and the decode still reflect the old value.
- R4: Control bit 2 sets the end of low RAM. When bit 2 is 1, low RAM ends at 0x80000; when it is 0, it ends at 0xA0000. A low-RAM access selects low RAM with the physical address equal to the CPU address.
- R5: With control bit 1 set, a read in 0xE0000–0xFFFFF selects ROM and a write there selects shadow RAM.
- R6: With control bit 1 clear, a read in 0xE0000–0xFFFFF selects shadow RAM and a write there raises write inhibit.
- R7: The split block is enabled only while control bit 3 is 0. Its CPU base is base-register bits 3:0 times 1 MB.
- R8: When control bit 2 is 1, the split block is 384 KB with physical origin 0x80000. When it is 0, the block is 256 KB with origin 0xA0000. A split access maps to (CPU address mod block size) + origin.
- R9: Low RAM and the top window take priority over the split block. With no strobe, nothing is selected. When both strobes are high, the access counts as a write. At most one select is active at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | RA_W | Register index |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register readback |
| cpu_addr | input | ADDR_W | CPU byte address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| phys_addr | output | ADDR_W | Translated physical address |
| sel_low | output | 1 | Low RAM selected |
| sel_split | output | 1 | Split block selected |
| sel_rom | output | 1 | ROM selected |
| sel_shadow | output | 1 | Shadow RAM selected |
| wr_inhibit | output | 1 | Write discarded |

## Verification
The only state is the two control registers. A corrupted bit shows up at the ports on the first access after the edge that stores it. A wrong ROM bit swaps ROM with shadow RAM, or shadow RAM with write inhibit, in the top window. A wrong low bit moves both the end of low RAM and the split origin. A wrong disable bit makes a split hit vanish or appear. Errors in the modulo path are purely combinational and show in phys_addr in the same cycle. For that reason the vectors place split addresses at block starts, at block ends, just past the end, and at bases where 1 MB is not a multiple of 384 KB.

// File: rtl/split_remap_pkg.sv
package split_remap_pkg;

    localparam int REG_W = 8;

    // control register bit positions
    localparam int CTL_ROM_BIT   = 1;
    localparam int CTL_LOW_BIT   = 2;
    localparam int CTL_NOSPL_BIT = 3;

    localparam logic [REG_W-1:0] BASE_RST = 8'h00;
    localparam logic [REG_W-1:0] CTL_RST  = 8'h02;
    localparam logic [REG_W-1:0] IDLE_RD  = 8'hFF;

    // window constants (20-bit, below 1 MB)
    localparam logic [19:0] LOW_END_SHORT = 20'h80000;
    localparam logic [19:0] LOW_END_LONG  = 20'hA0000;
    localparam logic [19:0] TOP_WIN_LO    = 20'hE0000;
    localparam logic [19:0] SPL_SIZE_BIG  = 20'h60000;
    localparam logic [19:0] SPL_SIZE_SML  = 20'h40000;

    typedef struct packed {
        logic [REG_W-1:0] base;
        logic [REG_W-1:0] ctl;
    } remap_regs_t;

endpackage

// File: rtl/split_remap_regs.sv
module split_remap_regs
    import split_remap_pkg::*;
#(
    parameter int RA_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RA_W-1:0]  reg_addr,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic [3:0]       base_mb,
    output logic             ctl_rom,
    output logic             ctl_low,
    output logic             ctl_nospl
);

    localparam logic [RA_W-1:0] IDX_BASE = RA_W'(0);
    localparam logic [RA_W-1:0] IDX_CTL  = RA_W'(1);

    remap_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (reg_wr) begin
            if (reg_addr == IDX_BASE) regs_d.base = reg_wdata;
            if (reg_addr == IDX_CTL)  regs_d.ctl  = reg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.base <= BASE_RST;
            regs_q.ctl  <= CTL_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        if (reg_addr == IDX_BASE)     reg_rdata = regs_q.base;
        else if (reg_addr == IDX_CTL) reg_rdata = regs_q.ctl;
        else                          reg_rdata = IDLE_RD;
    end

    assign base_mb   = regs_q.base[3:0];
    assign ctl_rom   = regs_q.ctl[CTL_ROM_BIT];
    assign ctl_low   = regs_q.ctl[CTL_LOW_BIT];
    assign ctl_nospl = regs_q.ctl[CTL_NOSPL_BIT];

endmodule

// File: rtl/split_remap_mod.sv
module split_remap_mod #(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              big,
    output logic [18:0]       offset
);

    // 384 KB = 3 x 128 KB: fold bits above 17 modulo 3
    localparam int UP_W = ADDR_W - 17;

    function automatic logic [1:0] fold3(input logic [UP_W-1:0] v);
        logic [1:0] r;
        r = 2'd0;
        for (int i = UP_W - 1; i >= 0; i--) begin
            case ({r, v[i]})
                3'b000:  r = 2'd0;
                3'b001:  r = 2'd1;
                3'b010:  r = 2'd2;
                3'b011:  r = 2'd0;
                3'b100:  r = 2'd1;
                3'b101:  r = 2'd2;
                default: r = 2'd0;
            endcase
        end
        return r;
    endfunction

    logic [1:0] chunk;

    always_comb begin
        chunk = fold3(addr[ADDR_W-1:17]);
        if (big) offset = {chunk, addr[16:0]};
        else     offset = {1'b0, addr[17:0]};
    end

endmodule

// File: rtl/split_remap_decode.sv
module split_remap_decode
    import split_remap_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [3:0]        base_mb,
    input  logic              ctl_rom,
    input  logic              ctl_low,
    input  logic              ctl_nospl,
    output logic [ADDR_W-1:0] phys_addr,
    output logic              sel_low,
    output logic              sel_split,
    output logic              sel_rom,
    output logic              sel_shadow,
    output logic              wr_inhibit
);

    localparam int HI_W = ADDR_W - 20;

    logic [18:0]     offset;
    logic [19:0]     spl_phys;
    logic [19:0]     spl_size;
    logic [19:0]     low_end;
    logic [HI_W-1:0] base_ext;
    logic            below_mb, in_low, in_top, in_split, access, do_rd;

    split_remap_mod #(.ADDR_W(ADDR_W)) u_mod (
        .addr   (cpu_addr),
        .big    (ctl_low),
        .offset (offset)
    );

    always_comb begin
        base_ext = HI_W'(base_mb);
        below_mb = (cpu_addr[ADDR_W-1:20] == '0);
        low_end  = ctl_low ? LOW_END_SHORT : LOW_END_LONG;
        spl_size = ctl_low ? SPL_SIZE_BIG  : SPL_SIZE_SML;
        spl_phys = (ctl_low ? LOW_END_SHORT : LOW_END_LONG) + {1'b0, offset};

        in_low   = below_mb && (cpu_addr[19:0] < low_end);
        in_top   = below_mb && (cpu_addr[19:0] >= TOP_WIN_LO);
        in_split = !ctl_nospl && (cpu_addr[ADDR_W-1:20] == base_ext)
                   && (cpu_addr[19:0] < spl_size) && !in_low && !in_top;

        access = cpu_rd || cpu_wr;
        do_rd  = cpu_rd && !cpu_wr;

        sel_low    = access && in_low;
        sel_split  = access && in_split;
        sel_rom    = do_rd && in_top && ctl_rom;
        sel_shadow = in_top && ((do_rd && !ctl_rom) || (cpu_wr && ctl_rom));
        wr_inhibit = cpu_wr && in_top && !ctl_rom;

        phys_addr = in_split ? ADDR_W'(spl_phys) : cpu_addr;
    end

endmodule

// File: rtl/split_remap_unit.sv
module split_remap_unit
    import split_remap_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int RA_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic [ADDR_W-1:0] phys_addr,
    output logic              sel_low,
    output logic              sel_split,
    output logic              sel_rom,
    output logic              sel_shadow,
    output logic              wr_inhibit
);

    logic [3:0] base_mb;
    logic       ctl_rom, ctl_low, ctl_nospl;

    split_remap_regs #(.RA_W(RA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .base_mb   (base_mb),
        .ctl_rom   (ctl_rom),
        .ctl_low   (ctl_low),
        .ctl_nospl (ctl_nospl)
    );

    split_remap_decode #(.ADDR_W(ADDR_W)) u_dec (
        .cpu_addr   (cpu_addr),
        .cpu_rd     (cpu_rd),
        .cpu_wr     (cpu_wr),
        .base_mb    (base_mb),
        .ctl_rom    (ctl_rom),
        .ctl_low    (ctl_low),
        .ctl_nospl  (ctl_nospl),
        .phys_addr  (phys_addr),
        .sel_low    (sel_low),
        .sel_split  (sel_split),
        .sel_rom    (sel_rom),
        .sel_shadow (sel_shadow),
        .wr_inhibit (wr_inhibit)
    );

endmodule

// File: rtl/split_remap_checks.sv
module split_remap_checks #(
    parameter int ADDR_W = 24,
    parameter int RA_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [RA_W-1:0]   reg_addr,
    input logic              reg_wr,
    input logic [7:0]        reg_wdata,
    input logic [7:0]        reg_rdata,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic [ADDR_W-1:0] phys_addr,
    input logic              sel_low,
    input logic              sel_split,
    input logic              sel_rom,
    input logic              sel_shadow,
    input logic              wr_inhibit
);

    localparam logic [ADDR_W-1:0] TOP_LO = ADDR_W'(32'hE0000);
    localparam logic [ADDR_W-1:0] ONE_MB = ADDR_W'(32'h100000);
    localparam logic [ADDR_W-1:0] LOW_MX = ADDR_W'(32'hA0000);
    localparam logic [ADDR_W-1:0] SPL_LO = ADDR_W'(32'h80000);

    p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_low, sel_split, sel_rom, sel_shadow, wr_inhibit}));

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_rd || cpu_wr) |-> !(sel_low || sel_split || sel_rom || sel_shadow || wr_inhibit));

    p_ctl_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_W'(1)) |=> (reg_addr != RA_W'(1) || reg_rdata == $past(reg_wdata)));

    p_rom_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_rom |-> (cpu_rd && !cpu_wr && cpu_addr >= TOP_LO && cpu_addr < ONE_MB));

    p_inhibit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_inhibit |-> (cpu_wr && cpu_addr >= TOP_LO && cpu_addr < ONE_MB));

    p_low_ident_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_low |-> (phys_addr == cpu_addr && cpu_addr < LOW_MX));

    p_split_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_split |-> (phys_addr >= SPL_LO && phys_addr < TOP_LO && cpu_addr >= ONE_MB));

endmodule

bind split_remap_unit split_remap_checks #(.ADDR_W(ADDR_W), .RA_W(RA_W)) u_chk (.*);

// File: tb/split_remap_unit_test.sv
module split_remap_unit_test;

    localparam int AW = 24;
    localparam int RW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [RW-1:0] reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [AW-1:0] phys_addr;
    logic          sel_low, sel_split, sel_rom, sel_shadow, wr_inhibit;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    split_remap_unit #(.ADDR_W(AW), .RA_W(RW)) uut (.*);

    // select order {low, split, rom, shadow, inhibit}
    typedef struct packed {
        logic [7:0]    base;
        logic [7:0]    ctl;
        logic [AW-1:0] addr;
        logic          rd;
        logic          wr;
        logic [4:0]    sel;
        logic [AW-1:0] phys;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{8'h0, 8'h02, 24'h000010, 1'b1, 1'b0, 5'b10000, 24'h000010}, // R4
        '{8'h0, 8'h02, 24'h09FFFF, 1'b1, 1'b0, 5'b10000, 24'h09FFFF}, // R4
        '{8'h0, 8'h06, 24'h080000, 1'b1, 1'b0, 5'b00000, 24'h080000}, // R4
        '{8'h0, 8'h06, 24'h07FFFF, 1'b0, 1'b1, 5'b10000, 24'h07FFFF}, // R4
        '{8'h0, 8'h02, 24'h0E0000, 1'b1, 1'b0, 5'b00100, 24'h0E0000}, // R5
        '{8'h0, 8'h02, 24'h0FFFFF, 1'b0, 1'b1, 5'b00010, 24'h0FFFFF}, // R5
        '{8'h0, 8'h00, 24'h0E1234, 1'b1, 1'b0, 5'b00010, 24'h0E1234}, // R6
        '{8'h0, 8'h00, 24'h0F0000, 1'b0, 1'b1, 5'b00001, 24'h0F0000}, // R6
        '{8'h1, 8'h06, 24'h100000, 1'b1, 1'b0, 5'b01000, 24'h0C0000}, // R8
        '{8'h1, 8'h06, 24'h15FFFF, 1'b0, 1'b1, 5'b01000, 24'h0BFFFF}, // R8
        '{8'h1, 8'h06, 24'h160000, 1'b1, 1'b0, 5'b00000, 24'h160000}, // R8
        '{8'h1, 8'h02, 24'h100000, 1'b1, 1'b0, 5'b01000, 24'h0A0000}, // R8
        '{8'h1, 8'h02, 24'h13FFFF, 1'b1, 1'b0, 5'b01000, 24'h0DFFFF}, // R8
        '{8'h1, 8'h02, 24'h140000, 1'b1, 1'b0, 5'b00000, 24'h140000}, // R8
        '{8'h1, 8'h0A, 24'h100000, 1'b1, 1'b0, 5'b00000, 24'h100000}, // R7
        '{8'h5, 8'h02, 24'h512345, 1'b1, 1'b0, 5'b01000, 24'h0B2345}, // R7
        '{8'h5, 8'h06, 24'h523456, 1'b0, 1'b1, 5'b01000, 24'h0C3456}, // R8
        '{8'h0, 8'h02, 24'h000010, 1'b0, 1'b0, 5'b00000, 24'h000010}, // R9
        '{8'h0, 8'h02, 24'h0E0000, 1'b1, 1'b1, 5'b00010, 24'h0E0000}  // R9
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [RW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_reg(input string req, input logic [RW-1:0] a, input logic [7:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, {24'h0, reg_rdata}, {24'h0, exp});
    endtask

    function automatic logic [4:0] sels();
        return {sel_low, sel_split, sel_rom, sel_shadow, wr_inhibit};
    endfunction

    task automatic access(input string req, input logic [AW-1:0] a, input logic rd, input logic wr,
                          input logic [4:0] esel, input logic [AW-1:0] ephys);
        @(negedge clk);
        cpu_addr = a; cpu_rd = rd; cpu_wr = wr;
        #2;
        check(req, {27'h0, sels()}, {27'h0, esel});
        check(req, {8'h0, phys_addr}, {8'h0, ephys});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        read_reg("R1", 2'd0, 8'h00);
        read_reg("R1", 2'd1, 8'h02);
        access("R1", 24'h0E8000, 1'b1, 1'b0, 5'b00100, 24'h0E8000);

        // R2 unused indices
        read_reg("R2", 2'd2, 8'hFF);
        read_reg("R2", 2'd3, 8'hFF);
        write_reg(2'd2, 8'h55);
        write_reg(2'd3, 8'hAA);
        read_reg("R2", 2'd0, 8'h00);
        read_reg("R2", 2'd1, 8'h02);
        read_reg("R2", 2'd2, 8'hFF);

        // R3 write visibility at the capturing edge
        @(negedge clk);
        reg_addr = 2'd1; reg_wdata = 8'h00; reg_wr = 1'b1;
        cpu_addr = 24'h0F0000; cpu_rd = 1'b0; cpu_wr = 1'b1;
        #2;
        check("R3", {24'h0, reg_rdata}, 32'h02);
        check("R3", {27'h0, sels()}, 32'b00010);
        @(negedge clk);
        reg_wr = 1'b0;
        #2;
        check("R3", {24'h0, reg_rdata}, 32'h00);
        check("R3", {27'h0, sels()}, 32'b00001);

        // table walk
        for (int i = 0; i < NV; i++) begin
            write_reg(2'd0, VEC[i].base);
            write_reg(2'd1, VEC[i].ctl);
            access($sformatf("vector %0d R4-set", i), VEC[i].addr, VEC[i].rd, VEC[i].wr,
                   VEC[i].sel, VEC[i].phys);
        end

        // R9 priority: split base 0 overlaps low RAM, low wins
        write_reg(2'd0, 8'h00);
        write_reg(2'd1, 8'h06);
        access("R9", 24'h001000, 1'b1, 1'b0, 5'b10000, 24'h001000);
        // R7 upper base bits ignored: base 0x13 acts as 3 MB
        write_reg(2'd0, 8'h13);
        write_reg(2'd1, 8'h02);
        access("R7", 24'h300004, 1'b1, 1'b0, 5'b01000, 24'h0A0004);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (all requirements): actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule